// File: doc/BRIEF.md
# Firmware-Region Write Guard Register

This block holds the control register that decides whether the firmware region of an SPI flash device may be written. Software reaches it through a simple register port. Every access on that port carries a flag that says whether the requester runs in system management mode (SMM). Each processor also reports its own "in SMM" status on a separate input. From the register fields and those status inputs, the block drives a write-permitted level to the flash access path.

Setting the write-enable field depends on who asks. While the lock field is set, only an SMM access may turn write-enable on. An attempt from outside SMM is refused and raises a system-management interrupt request, so handler firmware can react to it. A second field goes further: when it is set, a write to the flash is permitted only while every processor is in SMM. The lock field and that SMM-only field cannot be cleared by software once they are set. A sticky trap flag records refused attempts until software clears it.

Top module: `fw_wr_guard`

## Requirements
- R1: After reset, every register field is 0, `flash_wr_ok` is 0 and `smi_req` is 0.
- R2: The register answers only at address `REG_OFS` (default 0xFC). Its read value carries write-enable at bit 0, lock at bit 1, SMM-only protect at bit 5 and the trap flag at bit 7. All other bits read 0. An access to any other address reads 0 and changes nothing.
- R3: While lock is 0, a write with bit 0 set turns write-enable on, from any mode.
- R4: While lock is 1, a write with bit 0 set from an SMM-flagged access turns write-enable on.
- R5: While lock is 1 and write-enable is 0, a write with bit 0 set from a non-SMM access is refused in three ways. Write-enable stays 0. `smi_req` is high for exactly the one cycle after the write. Bits 1 and 5 of that same write still take effect. A non-SMM write of bit 0 = 1 while write-enable is already 1 raises no request.
- R6: A write with bit 0 clear turns write-enable off, from any mode.
- R7: Lock (bit 1) and SMM-only protect (bit 5) are set by writing 1. Once set, they stay set until reset, and writing 0 to them has no effect.
- R8: The trap flag (bit 7) is set by every refused attempt. A write with bit 7 = 1 clears it, and a write with bit 7 = 0 leaves it unchanged. If a refusal and a clear arrive in the same write, the flag ends up set.
- R9: While SMM-only protect is 0, `flash_wr_ok` equals write-enable, whatever the processor status inputs are.
- R10: While SMM-only protect is 1, `flash_wr_ok` is 1 only when write-enable is 1 and every bit of `cpu_in_smm` is 1. It follows `cpu_in_smm` in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| acc_wr | input | 1 | Write strobe of the register port |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | DATA_W | Write data |
| acc_smm | input | 1 | The current access comes from SMM |
| acc_rdata | output | DATA_W | Read data for `acc_addr` (combinational) |
| cpu_in_smm | input | NUM_CPU | Per-processor "in SMM" status |
| flash_wr_ok | output | 1 | The firmware region may be written |
| smi_req | output | 1 | One-cycle SMI request on a refused enable attempt |

## Verification
A corrupted write-enable bit shows up immediately as a wrong `flash_wr_ok` level. It also appears in the read value in the very cycle after the write that should have set or cleared it. A lock or protect bit that fails to hold shows up only on a later access. After a non-SMM enable attempt, the write-enable bit reads back as 1, and `smi_req` does not pulse. For that reason the bench writes 0 to both sticky fields and then retries a refused set. A lost or duplicated trap shows as a missing or a stretched `smi_req` one cycle after the write, and as a wrong bit 7 on the next read.

// File: rtl/fwg_pkg.sv
`timescale 1ns/1ps
package fwg_pkg;
  // Bit positions of the register fields (decoded by software)
  localparam int WE_BIT   = 0;
  localparam int LOCK_BIT = 1;
  localparam int WP_BIT   = 5;
  localparam int TRAP_BIT = 7;
  localparam int MIN_DW   = TRAP_BIT + 1;

  typedef struct packed {
    logic we;    // write enable
    logic lock;  // enable may only be set from SMM
    logic wp;    // writes need all processors in SMM
  } fwg_ctl_t;
endpackage

// File: rtl/fwg_rst_sync.sv
`timescale 1ns/1ps
module fwg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/fwg_ctl_reg.sv
`timescale 1ns/1ps
module fwg_ctl_reg
  import fwg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_sn,
  input  logic     wr_hit,
  input  logic     set_we,
  input  logic     set_lock,
  input  logic     set_wp,
  input  logic     smm,
  output fwg_ctl_t ctl_q,
  output logic     blk
);
  fwg_ctl_t ctl_d;

  // next state
  always_comb begin
    ctl_d = ctl_q;
    blk   = 1'b0;
    if (wr_hit) begin
      ctl_d.lock = ctl_q.lock | set_lock;
      ctl_d.wp   = ctl_q.wp | set_wp;
      if (!set_we) begin
        ctl_d.we = 1'b0;
      end else if (!ctl_q.we) begin
        if (ctl_q.lock && !smm) blk = 1'b1;
        else                    ctl_d.we = 1'b1;
      end
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ctl_q <= '0;
    else if (wr_hit) ctl_q <= ctl_d;
  end

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctl_q.lock |=> ctl_q.lock);
  // R7
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctl_q.wp |=> ctl_q.wp);
  // R6
  we_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_hit && !set_we) |=> !ctl_q.we);
  // R3
  open_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_hit && set_we && !ctl_q.lock) |=> ctl_q.we);
  // R4
  smm_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_hit && set_we && smm) |=> ctl_q.we);
  // R5
  blocked_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    blk |=> !ctl_q.we);
endmodule

// File: rtl/fwg_trap.sv
`timescale 1ns/1ps
module fwg_trap (
  input  logic clk,
  input  logic rst_sn,
  input  logic blk_i,
  input  logic wr_hit,
  input  logic clr_i,
  output logic smi_req,
  output logic trap_sts
);
  logic sts_d;
  logic smi_d;

  always_comb begin
    smi_d = blk_i;
    sts_d = trap_sts;
    if (wr_hit && clr_i) sts_d = 1'b0;
    if (blk_i)           sts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      smi_req  <= 1'b0;
      trap_sts <= 1'b0;
    end else begin
      smi_req  <= smi_d;
      trap_sts <= sts_d;
    end
  end

  // R5
  smi_source_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    smi_req |-> $past(blk_i));
  // R8
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    blk_i |=> trap_sts);
  // R8
  sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (trap_sts && !(wr_hit && clr_i)) |=> trap_sts);
endmodule

// File: rtl/fwg_permit.sv
`timescale 1ns/1ps
module fwg_permit #(
  parameter int NUM_CPU = 4
) (
  input  logic               we,
  input  logic               wp,
  input  logic [NUM_CPU-1:0] cpu_in_smm,
  output logic               wr_ok
);
  logic all_smm;

  assign all_smm = &cpu_in_smm;

  always_comb begin
    wr_ok = we & (~wp | all_smm);
  end
endmodule

// File: rtl/fw_wr_guard.sv
`timescale 1ns/1ps
module fw_wr_guard
  import fwg_pkg::*;
#(
  parameter int               ADDR_W  = 12,
  parameter int               DATA_W  = 8,
  parameter int               NUM_CPU = 4,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'hFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_wr,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  input  logic               acc_smm,
  output logic [DATA_W-1:0]  acc_rdata,
  input  logic [NUM_CPU-1:0] cpu_in_smm,
  output logic               flash_wr_ok,
  output logic               smi_req
);
  localparam int RST_STAGES = 2;

  logic     rst_sn;
  logic     hit;
  logic     wr_hit;
  logic     blk;
  logic     trap_sts;
  fwg_ctl_t ctl_q;
  logic     unused_wbits;

  initial begin
    if (DATA_W < MIN_DW) $error("DATA_W too small for the field layout");
  end

  fwg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign hit          = (acc_addr == REG_OFS);
  assign wr_hit       = acc_wr & hit;
  assign unused_wbits = ^acc_wdata;

  fwg_ctl_reg u_ctl (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .wr_hit   (wr_hit),
    .set_we   (acc_wdata[WE_BIT]),
    .set_lock (acc_wdata[LOCK_BIT]),
    .set_wp   (acc_wdata[WP_BIT]),
    .smm      (acc_smm),
    .ctl_q    (ctl_q),
    .blk      (blk)
  );

  fwg_trap u_trap (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .blk_i    (blk),
    .wr_hit   (wr_hit),
    .clr_i    (acc_wdata[TRAP_BIT]),
    .smi_req  (smi_req),
    .trap_sts (trap_sts)
  );

  fwg_permit #(.NUM_CPU(NUM_CPU)) u_perm (
    .we         (ctl_q.we),
    .wp         (ctl_q.wp),
    .cpu_in_smm (cpu_in_smm),
    .wr_ok      (flash_wr_ok)
  );

  // read mux
  always_comb begin
    acc_rdata = '0;
    if (hit) begin
      acc_rdata[WE_BIT]   = ctl_q.we;
      acc_rdata[LOCK_BIT] = ctl_q.lock;
      acc_rdata[WP_BIT]   = ctl_q.wp;
      acc_rdata[TRAP_BIT] = trap_sts;
    end
  end

  // R10
  permit_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctl_q.wp && !(&cpu_in_smm)) |-> !flash_wr_ok);
  // R9
  permit_open_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctl_q.wp |-> (flash_wr_ok == ctl_q.we));
  // R2
  miss_nochg_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_wr && !hit) |=> $stable(ctl_q));
endmodule

// File: tb/sim_fw_wr_guard.sv
`timescale 1ns/1ps
module sim_fw_wr_guard;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int NC = 4;
  localparam logic [AW-1:0] OFS = 12'hFC;

  logic          clk;
  logic          rst_n;
  logic          acc_wr;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic          acc_smm;
  logic [DW-1:0] acc_rdata;
  logic [NC-1:0] cpu_in_smm;
  logic          flash_wr_ok;
  logic          smi_req;

  int n_chk;
  int n_err;
  bit done;

  typedef struct {
    logic [DW-1:0] rd;
    logic          ok;
    logic          smi;
    string         tag;
  } exp_t;

  exp_t sb[$];

  fw_wr_guard #(.ADDR_W(AW), .DATA_W(DW), .NUM_CPU(NC), .REG_OFS(OFS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_smm(acc_smm), .acc_rdata(acc_rdata),
    .cpu_in_smm(cpu_in_smm), .flash_wr_ok(flash_wr_ok), .smi_req(smi_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: one cycle of stimulus, expectation for the cycle after its edge
  task automatic step(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic smm, input logic [NC-1:0] cpus,
                      input logic [DW-1:0] erd, input logic eok, input logic esmi,
                      input string tag);
    exp_t e;
    @(negedge clk);
    acc_wr = wr; acc_addr = a; acc_wdata = wd; acc_smm = smm; cpu_in_smm = cpus;
    e.rd = erd; e.ok = eok; e.smi = esmi; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: samples 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "rdata", acc_rdata, e.rd);
        cmp(e.tag, "flash_wr_ok", {7'd0, flash_wr_ok}, {7'd0, e.ok});
        cmp(e.tag, "smi_req", {7'd0, smi_req}, {7'd0, e.smi});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    acc_wr = 1'b0;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    acc_smm = 1'b0; cpu_in_smm = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    step(0, OFS, 8'h00, 0, 4'h0, 8'h00, 0, 0, "R1 reset");
    // R2 other address reads 0
    step(0, 12'h010, 8'h00, 0, 4'h0, 8'h00, 0, 0, "R2 miss read");
    // R3 open set from non-SMM; R9 ok ignores cpus
    step(1, OFS, 8'h01, 0, 4'h0, 8'h01, 1, 0, "R3 open set");
    step(0, OFS, 8'h00, 0, 4'h5, 8'h01, 1, 0, "R9 cpus ignored");
    // R6 clear
    step(1, OFS, 8'h00, 0, 4'h0, 8'h00, 0, 0, "R6 clear");
    // R2 write elsewhere has no effect
    step(1, 12'h07C, 8'hFF, 0, 4'h0, 8'h00, 0, 0, "R2 miss write");
    step(0, OFS, 8'h00, 0, 4'h0, 8'h00, 0, 0, "R2 after miss");
    // R7 set lock
    step(1, OFS, 8'h02, 0, 4'h0, 8'h02, 0, 0, "R7 lock");
    // R5 refused set, R8 flag
    step(1, OFS, 8'h03, 0, 4'h0, 8'h82, 0, 1, "R5 refused");
    step(0, OFS, 8'h00, 0, 4'h0, 8'h82, 0, 0, "R5 pulse ends");
    // R8 clear with 1
    step(1, OFS, 8'h80, 0, 4'h0, 8'h02, 0, 0, "R8 w1c");
    // R5 other fields still taken
    step(1, OFS, 8'h21, 0, 4'h0, 8'hA2, 0, 1, "R5 wp taken");
    step(1, OFS, 8'h20, 0, 4'h0, 8'hA2, 0, 0, "R8 write0 keeps");
    step(1, OFS, 8'h80, 0, 4'h0, 8'h22, 0, 0, "R8 w1c again");
    // R4 SMM set, R10 permit
    step(1, OFS, 8'h01, 1, 4'hF, 8'h23, 1, 0, "R4 smm set");
    step(0, OFS, 8'h00, 0, 4'h7, 8'h23, 0, 0, "R10 one cpu out");
    step(0, OFS, 8'h00, 0, 4'hF, 8'h23, 1, 0, "R10 all in");
    // R5 already-set, no trap
    step(1, OFS, 8'h01, 0, 4'hF, 8'h23, 1, 0, "R5 already set");
    // R6 clear from non-SMM; R7 zeros ignored
    step(1, OFS, 8'h00, 0, 4'hF, 8'h22, 0, 0, "R7 sticky");
    // R8 refusal beats clear
    step(1, OFS, 8'h81, 0, 4'hF, 8'hA2, 0, 1, "R8 set wins");
    step(0, OFS, 8'h00, 0, 4'hF, 8'hA2, 0, 0, "R8 held");
    drain();

    // R7 only reset clears
    do_reset();
    step(0, OFS, 8'h00, 0, 4'hF, 8'h00, 0, 0, "R7 R1 after reset");
    step(1, OFS, 8'h01, 0, 4'h0, 8'h01, 1, 0, "R3 unlocked again");
    drain();

    acc_wr = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule